// File: doc/BRIEF.md
# Four-Channel Match Timer

This peripheral holds four 32-bit counters that step together from one shared prescaler. Each channel has its own enable, its own synchronous clear, a direction (up or down), a count-mode field and a compare value. When a count step lands on the compare value, that channel's status flag is raised. The channel's action bits then decide whether the flag drives the interrupt line, whether the counter restarts from zero, and whether the channel turns itself off. A typical use has one channel as a free-running time base and another as a periodic or one-shot event source.

Software reaches the block over a plain synchronous register port. Each register owns a 16-byte slot, and address bits [3:2] pick how a write is applied. Read data follows the address in the same cycle. A single level-sensitive interrupt output combines the flags whose interrupt enable is set.

Top module: `quad_match_timer`

## Requirements
- R1: Register slot = address bits [11:4]; status 0x000, control 0x010, direction 0x020, counter n at 0x030+0x10*n, prescale 0x070, prescale count 0x080, action 0x090, compare n at 0x0A0+0x10*n, count mode 0x180; other slots read 0. For a write, address bits [3:2] choose the operation: 0 replaces the value, 1 ORs the data in, 2 clears the bits that are 1 in the data, and 3 inverts them. A read at any of the four offsets returns the same value.
- R2: Control bits [3:0] enable channels 0..3, and bits [7:4] are their clear bits. One edge after a clear bit reads 1, the counter and the shared prescale count become 0, and both stay at 0 while the bit remains 1, even if the channel is enabled.
- R3: The direction register keeps bit 4*n for channel n (0 counts up, 1 counts down). All other bits read 0. Counting is modulo 2^32 in both directions.
- R4: A counter that rolls over from 0xFFFFFFFF to 0, or from 0 to 0xFFFFFFFF, raises no flag unless the value it produces equals its compare value.
- R5: With prescale value P, enabled counters step once every P+1 cycles, and P=0 steps them every cycle. The prescale count runs 0..P while any channel is enabled and holds otherwise. Writes to the prescale count and to the counter registers are ignored.
- R6: The count-mode register has a 2-bit field per channel at bits [2n+1:2n]. Only value 0 lets the channel count; any other value freezes it.
- R7: When a count step of channel n produces a value equal to compare n, status bit n is set. Action bit 3n enables that flag onto the interrupt output. The interrupt output is the OR of the enabled flags.
- R8: If action bit 3n+1 is set, the next count step after a compare hit loads 0 instead of counting.
- R9: If action bit 3n+2 is set, a compare hit clears enable bit n at the same edge, and the counter holds the compare value.
- R10: Status bits [3:0] are the channel flags, and bit 4 and above read 0. Writing 1 at offset 0 or 8 clears a flag, offset 4 sets it, and offset 0xC inverts it. If a hardware hit and a software clear of the same flag fall in one cycle, the flag stays set.
- R11: After reset every register reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address: slot in [11:4], write operation in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Contents of the addressed register, same cycle |
| irq | output | 1 | Level interrupt, OR of the enabled status flags |

## Verification
The bench builds the timer with full 32-bit counters and shrinks the prescaler to 8 bits. At that width a down-count from zero reaches the all-ones value at once, so both roll-over directions are covered in a handful of cycles. The prescaler width is large enough for a divide-by-three run whose prescale count can be read on every cycle. Small compare values put the reload, self-stop and set-versus-clear collision cases within a few cycles of enabling a channel.

// File: rtl/quad_match_timer.sv
module quad_match_timer #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int NCH    = 4;
  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [SLOT_W-1:0] S_FLAG = SLOT_W'(8'h00);
  localparam logic [SLOT_W-1:0] S_CTRL = SLOT_W'(8'h01);
  localparam logic [SLOT_W-1:0] S_DIR  = SLOT_W'(8'h02);
  localparam logic [SLOT_W-1:0] S_CNT0 = SLOT_W'(8'h03);
  localparam logic [SLOT_W-1:0] S_PR   = SLOT_W'(8'h07);
  localparam logic [SLOT_W-1:0] S_PC   = SLOT_W'(8'h08);
  localparam logic [SLOT_W-1:0] S_MCR  = SLOT_W'(8'h09);
  localparam logic [SLOT_W-1:0] S_MAT0 = SLOT_W'(8'h0A);
  localparam logic [SLOT_W-1:0] S_MODE = SLOT_W'(8'h18);
  localparam logic [1:0] OP_PUT = 2'd0;
  localparam logic [1:0] OP_SET = 2'd1;
  localparam logic [1:0] OP_CLR = 2'd2;

  logic [SLOT_W-1:0]          slot;
  logic [1:0]                 op;
  logic [31:0]                wr_val;
  logic [NCH-1:0]             flag_q, flag_sw, dir_q, pend_q, step, hit, stop_hit, ien;
  logic [2*NCH-1:0]           ctrl_q, ctrl_sw, mode_q;
  logic [3*NCH-1:0]           mcr_q;
  logic [PRE_W-1:0]           pr_q, pc_q;
  logic [NCH-1:0][CNT_W-1:0]  cnt_q, cnt_nx, match_q;
  logic                       run, tick;

  function automatic logic [31:0] alias_wr(input logic [31:0] cur, input logic [31:0] d,
                                           input logic [1:0] o);
    case (o)
      OP_PUT:  return d;
      OP_SET:  return cur | d;
      OP_CLR:  return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction

  assign slot   = bus_addr[ADDR_W-1:4];
  assign op     = bus_addr[3:2];
  assign wr_val = alias_wr(bus_rdata, bus_wdata, op);

  assign run  = |ctrl_q[NCH-1:0];
  assign tick = run & (pc_q >= pr_q);
  assign irq  = |(flag_q & ien);

  always_comb begin
    bus_rdata = '0;
    case (slot)
      S_FLAG: bus_rdata[NCH-1:0]   = flag_q;
      S_CTRL: bus_rdata[2*NCH-1:0] = ctrl_q;
      S_DIR:  for (int n = 0; n < NCH; n++) bus_rdata[4*n] = dir_q[n];
      S_PR:   bus_rdata[PRE_W-1:0] = pr_q;
      S_PC:   bus_rdata[PRE_W-1:0] = pc_q;
      S_MCR:  bus_rdata[3*NCH-1:0] = mcr_q;
      S_MODE: bus_rdata[2*NCH-1:0] = mode_q;
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (slot == S_CNT0 + SLOT_W'(n)) bus_rdata[CNT_W-1:0] = cnt_q[n];
      if (slot == S_MAT0 + SLOT_W'(n)) bus_rdata[CNT_W-1:0] = match_q[n];
    end
  end

  // flags: offset 0 is write-one-to-clear, other offsets follow the common aliases
  always_comb begin
    flag_sw = flag_q;
    if (bus_we && slot == S_FLAG)
      flag_sw = (op == OP_PUT) ? (flag_q & ~bus_wdata[NCH-1:0]) : wr_val[NCH-1:0];
  end

  assign ctrl_sw = (bus_we && slot == S_CTRL) ? wr_val[2*NCH-1:0] : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ctrl_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      mcr_q  <= '0;
      pr_q   <= '0;
      pc_q   <= '0;
    end else begin
      flag_q <= flag_sw | hit;
      ctrl_q <= ctrl_sw & ~{{NCH{1'b0}}, stop_hit};
      if (bus_we && slot == S_DIR)
        for (int n = 0; n < NCH; n++) dir_q[n] <= wr_val[4*n];
      if (bus_we && slot == S_MODE) mode_q <= wr_val[2*NCH-1:0];
      if (bus_we && slot == S_MCR)  mcr_q  <= wr_val[3*NCH-1:0];
      if (bus_we && slot == S_PR)   pr_q   <= wr_val[PRE_W-1:0];
      if (|ctrl_q[2*NCH-1:NCH])     pc_q   <= '0;
      else if (run)                 pc_q   <= tick ? '0 : pc_q + 1'b1;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign step[n]     = tick & ctrl_q[n] & ~ctrl_q[NCH+n] & (mode_q[2*n +: 2] == 2'b00);
    assign cnt_nx[n]   = pend_q[n] ? '0 : (dir_q[n] ? cnt_q[n] - 1'b1 : cnt_q[n] + 1'b1);
    assign hit[n]      = step[n] & (cnt_nx[n] == match_q[n]);
    assign stop_hit[n] = hit[n] & mcr_q[3*n+2];
    assign ien[n]      = mcr_q[3*n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[n]   <= '0;
        pend_q[n]  <= 1'b0;
        match_q[n] <= '0;
      end else begin
        if (ctrl_q[NCH+n]) begin
          cnt_q[n]  <= '0;
          pend_q[n] <= 1'b0;
        end else if (step[n]) begin
          cnt_q[n]  <= cnt_nx[n];
          pend_q[n] <= hit[n] & mcr_q[3*n+1];
        end
        if (bus_we && slot == S_MAT0 + SLOT_W'(n)) match_q[n] <= wr_val[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/quad_match_timer_chk.sv
module quad_match_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_we,
  input logic [7:0]            ctrl_q,
  input logic [7:0]            mode_q,
  input logic [11:0]           mcr_q,
  input logic [3:0]            flag_q,
  input logic                  irq,
  input logic [3:0][CNT_W-1:0] cnt_q,
  input logic [3:0][CNT_W-1:0] match_q
);
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == 4'b0) |-> !irq);

  for (genvar n = 0; n < 4; n++) begin : g_chk
    p_clear_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[4+n] |=> (cnt_q[n] == '0));

    p_mode_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*n +: 2] != 2'b00 && !ctrl_q[4+n]) |=> $stable(cnt_q[n]));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[n] == '1 && match_q[n] != '0 && !flag_q[n] && !bus_we)
        |=> (cnt_q[n] != '0 || !flag_q[n]));

    p_hit_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[4+n] && !bus_we)
        |=> (cnt_q[n] == $past(cnt_q[n]) || cnt_q[n] != match_q[n] || flag_q[n]));

    p_self_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[n] && !ctrl_q[4+n] && mcr_q[3*n+2] && !bus_we)
        |=> (cnt_q[n] == $past(cnt_q[n]) || cnt_q[n] != match_q[n] || !ctrl_q[n]));
  end
endmodule

bind quad_match_timer quad_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_we  (bus_we),
  .ctrl_q  (ctrl_q),
  .mode_q  (mode_q),
  .mcr_q   (mcr_q),
  .flag_q  (flag_q),
  .irq     (irq),
  .cnt_q   (cnt_q),
  .match_q (match_q)
);

// File: tb/test_quad_match_timer.sv
`timescale 1ns/1ps
module test_quad_match_timer;
  localparam logic [11:0] A_FLAG = 12'h000, A_CTRL = 12'h010, A_DIR = 12'h020,
                          A_CNT0 = 12'h030, A_CNT2 = 12'h050, A_PR = 12'h070,
                          A_PC = 12'h080, A_MCR = 12'h090, A_MAT0 = 12'h0A0,
                          A_MAT1 = 12'h0B0, A_MAT2 = 12'h0C0, A_MAT3 = 12'h0D0,
                          A_MODE = 12'h180;
  localparam logic [11:0] SET = 12'h4, CLR = 12'h8, TGL = 12'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  logic [31:0] q_exp[$];
  int          q_irq[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  quad_match_timer #(.CNT_W(32), .PRE_W(8), .ADDR_W(12)) i_quad_match_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .irq(irq)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
  endtask
  task automatic rd(input logic [11:0] a, input logic [31:0] e, input int ei, input string tag);
    @(negedge clk); addr = a; we = 1'b0;
    q_exp.push_back(e); q_irq.push_back(ei); q_tag.push_back(tag);
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); we = 1'b0; end
  endtask
  task automatic clr_pulse(input logic [3:0] m);
    wr(A_CTRL | SET, {24'b0, m, 4'b0});
    wr(A_CTRL | CLR, {24'b0, m, 4'b0});
  endtask

  // monitor: pops expected items one cycle-phase after the driver placed the read
  always @(negedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [31:0] e;
      int ei;
      string t;
      e = q_exp.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
      if (ei >= 0) begin
        checks++;
        if (irq !== ei[0]) begin
          errors++;
          $display("FAIL %s: irq actual %b expected %0d", t, irq, ei);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd(A_FLAG, 0, 0, "R11 status");
    rd(A_CTRL, 0, 0, "R11 control");
    rd(A_DIR, 0, -1, "R11 direction");
    rd(A_CNT0, 0, -1, "R11 counter0");
    rd(A_PR, 0, -1, "R11 prescale");
    rd(A_PC, 0, -1, "R11 prescale count");
    rd(A_MCR, 0, -1, "R11 action");
    rd(A_MAT3, 0, -1, "R11 compare3");
    rd(A_MODE, 0, 0, "R11 mode");
    rd(12'h100, 0, -1, "R1 unmapped slot");

    // R1 write aliases
    wr(A_MAT1, 32'hF0F0_1234);       rd(A_MAT1, 32'hF0F0_1234, -1, "R1 plain");
    wr(A_MAT1 | SET, 32'h0000_000F); rd(A_MAT1, 32'hF0F0_123F, -1, "R1 set");
    wr(A_MAT1 | CLR, 32'hF000_0000); rd(A_MAT1 | CLR, 32'h00F0_123F, -1, "R1 clear");
    wr(A_MAT1 | TGL, 32'h0000_FFFF); rd(A_MAT1 | TGL, 32'h00F0_EDC0, -1, "R1 toggle");

    // R5 counter registers ignore writes
    wr(A_CNT0, 32'h1234); rd(A_CNT0, 0, -1, "R5 counter read-only");

    // R2 up count, P=0: five steps
    wr(A_CTRL, 32'h1); idle(4); wr(A_CTRL | CLR, 32'h1);
    rd(A_CNT0, 5, 0, "R2 enable counts");
    // R2 clear bit holds counter even while enabled
    wr(A_CTRL | SET, 32'h10); wr(A_CTRL | SET, 32'h1); idle(1);
    rd(A_CNT0, 0, -1, "R2 clear holds");
    wr(A_CTRL, 32'h0);

    // R3 / R4 direction and roll-over
    wr(A_MAT0, 32'h100);
    wr(A_DIR, 32'hFFFF); rd(A_DIR, 32'h1111, -1, "R3 direction bits");
    wr(A_DIR, 32'h1);
    wr(A_CTRL | SET, 32'h1); idle(1); wr(A_CTRL | CLR, 32'h1);
    rd(A_CNT0, 32'hFFFF_FFFE, -1, "R3 down count wraps");
    rd(A_FLAG, 0, 0, "R4 no flag on underflow");
    wr(A_DIR, 32'h0);
    wr(A_CTRL | SET, 32'h1); idle(2); wr(A_CTRL | CLR, 32'h1);
    rd(A_CNT0, 1, -1, "R3 up count wraps");
    rd(A_FLAG, 0, 0, "R4 no flag on overflow");

    // R5 prescaler P=2
    clr_pulse(4'h1);
    wr(A_PR, 2); rd(A_PR, 2, -1, "R5 prescale value");
    wr(A_CTRL | SET, 32'h1);
    rd(A_PC, 0, -1, "R5 pc 0");
    rd(A_PC, 1, -1, "R5 pc 1");
    rd(A_PC, 2, -1, "R5 pc 2");
    rd(A_CNT0, 1, -1, "R5 first step");
    idle(1);
    rd(A_CNT0, 1, -1, "R5 holds between ticks");
    rd(A_CNT0, 2, -1, "R5 second step");
    wr(A_CTRL | CLR, 32'h1);
    rd(A_CNT0, 2, -1, "R5 no step mid-period");
    wr(A_PC, 32'h55); rd(A_PC, 2, -1, "R5 pc read-only");
    wr(A_PR, 0);
    clr_pulse(4'h1);
    rd(A_PC, 0, -1, "R2 clear resets prescale count");

    // R6 non-timer mode freezes channel
    wr(A_MODE, 32'h1); rd(A_MODE, 1, -1, "R6 mode readback");
    wr(A_CTRL | SET, 32'h1); idle(2); wr(A_CTRL | CLR, 32'h1);
    rd(A_CNT0, 0, -1, "R6 frozen");
    wr(A_MODE, 32'h0);

    // R7 / R8 periodic reload on compare 3
    wr(A_MAT0, 3); wr(A_MCR, 32'h3);
    wr(A_CTRL | SET, 32'h1); idle(2);
    rd(A_FLAG, 0, 0, "R7 before hit");
    rd(A_FLAG, 1, 1, "R7 hit raises flag and irq");
    rd(A_CNT0, 0, -1, "R8 reload to zero");
    rd(A_CNT0, 1, -1, "R8 counts after reload");
    wr(A_CTRL | CLR, 32'h1);
    rd(A_CNT0, 3, -1, "R8 second period");
    wr(A_FLAG, 32'h1); rd(A_FLAG, 0, 0, "R10 write-one clears");

    // R9 self-stop
    clr_pulse(4'h1);
    wr(A_MAT0, 2); wr(A_MCR, 32'h5);
    wr(A_CTRL | SET, 32'h1); idle(2);
    rd(A_CTRL, 0, -1, "R9 enable cleared");
    rd(A_CNT0, 2, -1, "R9 holds compare value");
    rd(A_FLAG, 1, 1, "R9 flag with irq");
    wr(A_FLAG, 32'h1);

    // R7 masking and channel independence
    clr_pulse(4'hF);
    wr(A_MAT2, 2); wr(A_MCR, 32'h0);
    wr(A_CTRL | SET, 32'h4); idle(1); wr(A_CTRL | CLR, 32'h4);
    rd(A_FLAG, 32'h4, 0, "R7 flag without irq enable");
    rd(A_CNT0, 0, -1, "R7 channel0 untouched");
    rd(A_CNT2, 2, -1, "R7 channel2 count");
    wr(A_MCR | SET, 32'h40);
    rd(A_FLAG, 32'h4, 1, "R7 irq enable");
    wr(A_FLAG | CLR, 32'h4);
    rd(A_FLAG, 0, 0, "R10 clear alias");

    // R10 status aliases
    wr(A_FLAG | SET, 32'h1F); rd(A_FLAG, 32'hF, 1, "R10 set alias");
    wr(A_FLAG | TGL, 32'h3);  rd(A_FLAG, 32'hC, 1, "R10 toggle alias");
    wr(A_FLAG, 32'hC);        rd(A_FLAG, 0, 0, "R10 plain clear");

    // R10 hardware set beats software clear
    wr(A_MCR, 32'h0);
    clr_pulse(4'h2);
    wr(A_MAT1, 1);
    wr(A_CTRL | SET, 32'h2); wr(A_FLAG, 32'h2); wr(A_CTRL | CLR, 32'h2);
    rd(A_FLAG, 32'h2, 0, "R10 set wins collision");

    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule